// File: doc/BRIEF.md
# Transposed FIR Filter with Shared Subword Update Enables

This block is a finite impulse response filter in transposed form for signed two's-complement samples. The input sample is broadcast to one constant multiplier per tap. Each product is added to the registered partial sum of the next tap, so a pipeline register follows every adder in the accumulation chain. The coefficients are fixed by a parameter. The partial sums are kept at full precision, so the filter output never wraps.

Every partial-sum register is split into subwords of equal width. Each subword is rewritten only when its update enable is high. A single detector computes these enables for all taps from the incoming sample. The detector asks which subwords of a partial sum could carry anything other than copies of the sign. It combines that answer over the last TAPS accepted samples, because that window is every sample a partial sum can still contain. A subword that was not written is read back as sign extension. The arithmetic is therefore identical to an ungated filter. The enable vector is also brought out, so that clock-gating cells at chip level can use it.

Top module: `sw_fir_transposed`

## Requirements
- R1: Reset is synchronous and active low. After a clock edge with rst_n low, out_valid is 0 and out_sample is 0. Samples accepted before the reset contribute nothing to later outputs.
- R2: out_valid is 1 in the cycle after every clock edge where in_valid was 1, and 0 after every edge where in_valid was 0.
- R3: After the n-th accepted sample, out_sample equals sum over k of c_k * x[n-k]. The result is the exact two's-complement value in ACC_W = DATA_W + COEF_W + clog2(TAPS) bits. c_k is the signed field COEFS[k*COEF_W +: COEF_W], tap 0 multiplies the newest sample, and samples before the first one after reset count as 0.
- R4: A cycle with in_valid low does not count as a sample, and it leaves out_sample unchanged.
- R5: Bit i of sw_en is the update enable for bits [i*SUB_W +: SUB_W] of every partial-sum register. While in_valid is low, sw_en is all zeros.
- R6: Each sample has its own pattern. The sample is placed at the top of an ACC_W-bit word, shifted left by ACC_W-DATA_W. Subword i is needed when the bits of that word from position i*SUB_W up to the MSB are not all equal. While in_valid is high, sw_en is the OR of the pattern of the current sample and the patterns of the previous TAPS-1 accepted samples. A zero sample has an all-zero pattern.
- R7: The output stays exact when the amplitude drops from full scale to a few LSBs and rises again. A subword that is left unwritten never leaks stale contents into a result.
- R8: Full-scale inputs, with signs chosen to match the coefficient signs for the largest magnitude, give the exact result without wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample strobe; the sample is accepted on the rising edge |
| in_sample | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Filtered sample valid |
| out_sample | output | ACC_W | Signed full-precision filter output |
| sw_en | output | NSUB | Per-subword update enables for this cycle |

## Verification
The bench builds the filter with four taps, 8-bit samples, and eight 2-bit subwords instead of the default four 4-bit subwords. The finer split makes the enable pattern step through many distinct levels, from small samples to large ones. The 18-bit partial sum leaves one always-written bit between the subword region and the sign. The coefficient set includes both extremes, -128 and 127, so the worst-case growth of the partial sums is reached. Bursts of large samples followed by tiny ones force subwords to sit unwritten while their old contents are stale, then become live again.

// File: rtl/sw_fir_pkg.sv
// Package: width helpers shared by the subword-gated FIR and its checker.
// Assumes: every argument is a positive elaboration-time constant.
package sw_fir_pkg;

    // Full-precision partial-sum width: input + coefficient + tap growth.
    function automatic int psum_width(input int data_w, input int coef_w, input int taps);
        return data_w + coef_w + $clog2(taps);
    endfunction

    // Bits between the subword region and the sign bit; always written.
    function automatic int head_width(input int acc_w, input int nsub, input int sub_w);
        return acc_w - 1 - nsub * sub_w;
    endfunction

endpackage

// File: rtl/sw_noi_detect.sv
// Module: sw_noi_detect
// Computes which partial-sum subwords a single sample could make carry
// information. The sample is placed at the top of an ACC_W-bit word, which
// bounds the significance of every product and sum built from it. A subword
// is quiet only if it and everything above it (head bits included) equal
// the sign. The chain runs from the top, so the result is thermometer coded.
// Assumes: NSUB*SUB_W <= ACC_W-1 and ACC_W > DATA_W.
module sw_noi_detect #(
    parameter int DATA_W = 8,
    parameter int ACC_W  = 18,
    parameter int NSUB   = 4,
    parameter int SUB_W  = 4
) (
    input  logic [DATA_W-1:0] sample_i,
    output logic [NSUB-1:0]   need_o
);
    localparam int PAD_W  = ACC_W - DATA_W;
    localparam int HEAD_W = sw_fir_pkg::head_width(ACC_W, NSUB, SUB_W);

    logic [ACC_W-1:0] scaled;
    logic             sgn;
    logic [NSUB:0]    quiet;

    assign scaled = {sample_i, {PAD_W{1'b0}}};
    assign sgn    = scaled[ACC_W-1];

    // Head bits start the quiet chain when they exist.
    if (HEAD_W > 0) begin : g_head
        assign quiet[NSUB] = (scaled[ACC_W-2 -: HEAD_W] == {HEAD_W{sgn}});
    end else begin : g_nohead
        assign quiet[NSUB] = 1'b1;
    end

    // Each subword is quiet if it matches the sign and all above are quiet.
    for (genvar i = 0; i < NSUB; i++) begin : g_chain
        assign quiet[i] = quiet[i+1] && (scaled[i*SUB_W +: SUB_W] == {SUB_W{sgn}});
    end

    assign need_o = ~quiet[NSUB-1:0];
endmodule

// File: rtl/sw_en_window.sv
// Module: sw_en_window
// One shared enable generator for all taps. It ORs the current sample's
// pattern with the patterns of the previous TAPS-1 accepted samples, which
// covers every sample that any partial sum can still contain. It also
// registers the enable used at the last write (live mask), so that readers
// know which stored subwords are valid.
// Assumes: need_i is thermometer coded; accept_i is the sample strobe.
module sw_en_window #(
    parameter int NSUB = 4,
    parameter int TAPS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept_i,
    input  logic [NSUB-1:0] need_i,
    output logic [NSUB-1:0] upd_en_o,
    output logic [NSUB-1:0] live_o
);
    logic [NSUB-1:0] recent;
    logic [NSUB-1:0] window;

    if (TAPS > 1) begin : g_hist
        logic [NSUB-1:0] hist [TAPS-1];

        // Shift the per-sample patterns on every accepted sample.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int j = 0; j < TAPS-1; j++) hist[j] <= '0;
            end else if (accept_i) begin
                hist[0] <= need_i;
                for (int j = 1; j < TAPS-1; j++) hist[j] <= hist[j-1];
            end
        end

        // Merge the stored patterns of the recent samples.
        always_comb begin
            recent = '0;
            for (int j = 0; j < TAPS-1; j++) recent = recent | hist[j];
        end
    end else begin : g_nohist
        assign recent = '0;
    end

    assign window   = need_i | recent;
    assign upd_en_o = accept_i ? window : '0;

    // Remember which subwords the last write actually stored.
    always_ff @(posedge clk) begin
        if (!rst_n)        live_o <= '0;
        else if (accept_i) live_o <= window;
    end
endmodule

// File: rtl/sw_psum_reg.sv
// Module: sw_psum_reg
// Subword-partitioned partial-sum register. The sign and head bits are
// written on every load. Subword i is written only when upd_i[i] is high.
// On read, a subword that is not live is replaced by copies of the sign.
// Assumes: live_i marks the subwords written at the most recent load, and
// the true value fits in the live part.
module sw_psum_reg #(
    parameter int ACC_W = 18,
    parameter int NSUB  = 4,
    parameter int SUB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [NSUB-1:0]  upd_i,
    input  logic [NSUB-1:0]  live_i,
    input  logic [ACC_W-1:0] d_i,
    output logic [ACC_W-1:0] q_o
);
    localparam int LOW_W = NSUB * SUB_W;

    logic [ACC_W-1:LOW_W] top_q;

    // Sign and head bits follow every accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)      top_q <= '0;
        else if (load_i) top_q <= d_i[ACC_W-1:LOW_W];
    end

    assign q_o[ACC_W-1:LOW_W] = top_q;

    for (genvar i = 0; i < NSUB; i++) begin : g_sub
        logic [SUB_W-1:0] part_q;

        // Subword storage updated only under its own enable.
        always_ff @(posedge clk) begin
            if (!rst_n)        part_q <= '0;
            else if (upd_i[i]) part_q <= d_i[i*SUB_W +: SUB_W];
        end

        assign q_o[i*SUB_W +: SUB_W] = live_i[i] ? part_q : {SUB_W{top_q[ACC_W-1]}};
    end
endmodule

// File: rtl/sw_fir_transposed.sv
// Module: sw_fir_transposed (top)
// Transposed-form FIR. The sample is broadcast to TAPS constant
// multipliers. Partial sum k takes product k plus partial sum k+1, and the
// last tap takes its product alone. Partial sum 0 is the output. All
// partial-sum registers share one enable generator.
// Assumes: COEFS holds TAPS signed fields, tap 0 in the low COEF_W bits.
module sw_fir_transposed
    import sw_fir_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int COEF_W = 8,
    parameter int TAPS   = 4,
    parameter int NSUB   = 4,
    parameter int SUB_W  = 4,
    parameter logic [TAPS*COEF_W-1:0] COEFS = {8'h80, 8'h7F, 8'hFB, 8'h03}
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        in_valid,
    input  logic [DATA_W-1:0]                           in_sample,
    output logic                                        out_valid,
    output logic [psum_width(DATA_W, COEF_W, TAPS)-1:0] out_sample,
    output logic [NSUB-1:0]                             sw_en
);
    localparam int ACC_W = psum_width(DATA_W, COEF_W, TAPS);

    logic signed [ACC_W-1:0] x_ext;
    logic [NSUB-1:0]         need;
    logic [NSUB-1:0]         upd_en;
    logic [NSUB-1:0]         live;
    logic signed [ACC_W-1:0] nxt [TAPS];
    logic signed [ACC_W-1:0] q   [TAPS];

    assign x_ext = ACC_W'($signed(in_sample));

    sw_noi_detect #(
        .DATA_W(DATA_W), .ACC_W(ACC_W), .NSUB(NSUB), .SUB_W(SUB_W)
    ) u_detect (
        .sample_i(in_sample),
        .need_o  (need)
    );

    sw_en_window #(
        .NSUB(NSUB), .TAPS(TAPS)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept_i(in_valid),
        .need_i  (need),
        .upd_en_o(upd_en),
        .live_o  (live)
    );

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        localparam logic signed [COEF_W-1:0] CK = COEFS[k*COEF_W +: COEF_W];
        logic signed [ACC_W-1:0] prod;

        assign prod = x_ext * ACC_W'(CK);

        if (k == TAPS-1) begin : g_last
            assign nxt[k] = prod;
        end else begin : g_mid
            assign nxt[k] = prod + q[k+1];
        end

        sw_psum_reg #(
            .ACC_W(ACC_W), .NSUB(NSUB), .SUB_W(SUB_W)
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .load_i(in_valid),
            .upd_i (upd_en),
            .live_i(live),
            .d_i   (nxt[k]),
            .q_o   (q[k])
        );
    end

    // Output valid trails the accepted sample by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    assign out_sample = q[0];
    assign sw_en      = upd_en;
endmodule

// File: rtl/sw_fir_transposed_chk.sv
// Module: sw_fir_transposed_chk
// Port-level temporal checks for sw_fir_transposed, attached by bind.
// Assumes: the same clock and reset as the filter.
module sw_fir_transposed_chk #(
    parameter int DATA_W = 8,
    parameter int NSUB   = 4,
    parameter int ACC_W  = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_sample,
    input logic              out_valid,
    input logic [ACC_W-1:0]  out_sample,
    input logic [NSUB-1:0]   sw_en
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_sample == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R4
    hold_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_sample));

    // R5
    en_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (sw_en == '0));

    // R6
    en_thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en & (sw_en + NSUB'(1))) == '0);

    // R6
    en_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sample != '0) |-> sw_en[0]);
endmodule

bind sw_fir_transposed sw_fir_transposed_chk #(
    .DATA_W(DATA_W), .NSUB(NSUB), .ACC_W(ACC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .out_valid (out_valid),
    .out_sample(out_sample),
    .sw_en     (sw_en)
);

// File: tb/sw_fir_transposed_test.sv
// Bench: seeded random and directed stimulus against a reference
// convolution and a reference enable window, both built from the requirements.
module sw_fir_transposed_test;
    localparam int DATA_W = 8;
    localparam int COEF_W = 8;
    localparam int TAPS   = 4;
    localparam int NSUB   = 8;
    localparam int SUB_W  = 2;
    localparam int ACC_W  = DATA_W + COEF_W + $clog2(TAPS);
    localparam logic [TAPS*COEF_W-1:0] TB_COEFS = {8'h80, 8'h7F, 8'hFB, 8'h03};

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic [DATA_W-1:0] in_sample;
    logic              out_valid;
    logic [ACC_W-1:0]  out_sample;
    logic [NSUB-1:0]   sw_en;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    logic signed [DATA_W-1:0] hist [TAPS];
    logic signed [ACC_W-1:0]  last_out;

    always #4 clk = ~clk;

    sw_fir_transposed #(
        .DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS),
        .NSUB(NSUB), .SUB_W(SUB_W), .COEFS(TB_COEFS)
    ) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_sample(out_sample), .sw_en(sw_en)
    );

    function automatic logic signed [ACC_W-1:0] ref_out();
        logic signed [ACC_W-1:0]  s = '0;
        logic signed [COEF_W-1:0] c;
        for (int k = 0; k < TAPS; k++) begin
            c = TB_COEFS[k*COEF_W +: COEF_W];
            s = s + ACC_W'(hist[k]) * ACC_W'(c);
        end
        return s;
    endfunction

    function automatic logic [NSUB-1:0] pat(input logic [DATA_W-1:0] x);
        logic signed [ACC_W-1:0] y;
        logic signed [ACC_W-1:0] t;
        logic [NSUB-1:0] p;
        y = {x, {(ACC_W-DATA_W){1'b0}}};
        for (int i = 0; i < NSUB; i++) begin
            t = y >>> (i*SUB_W);
            p[i] = (t != '0) && (t != '1);
        end
        return p;
    endfunction

    function automatic logic [NSUB-1:0] exp_en(input logic v, input logic [DATA_W-1:0] d);
        logic [NSUB-1:0] e;
        if (!v) return '0;
        e = pat(d);
        for (int j = 0; j < TAPS-1; j++) e = e | pat(hist[j]);
        return e;
    endfunction

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_sample = '0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < TAPS; k++) hist[k] = '0;
        last_out = '0;
        check("R1", "out_valid after reset", longint'(out_valid), 0);
        check("R1", "out_sample after reset", longint'($signed(out_sample)), 0);
        check("R1", "sw_en after reset", longint'(sw_en), 0);
    endtask

    // Called just after a falling edge; returns just after the next one.
    task automatic step(input logic v, input logic [DATA_W-1:0] d, input string tag);
        in_valid = v;
        in_sample = d;
        #1;
        check(v ? "R6" : "R5", "sw_en", longint'(sw_en), longint'(exp_en(v, d)));
        @(posedge clk);
        if (v) begin
            for (int k = TAPS-1; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = d;
        end
        @(negedge clk);
        check("R2", "out_valid", longint'(out_valid), longint'(v));
        if (v) begin
            last_out = ref_out();
            check(tag, "out_sample", longint'($signed(out_sample)), longint'(last_out));
        end else begin
            check("R4", "held out_sample", longint'($signed(out_sample)), longint'(last_out));
        end
    endtask

    function automatic logic [DATA_W-1:0] low_amp();
        int t = int'($urandom_range(3)) - 2;
        return DATA_W'(t);
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R3 impulse response in tap order, with idle gaps (R4)
        step(1'b1, 8'sd1, "R3");
        step(1'b0, 8'sd99, "R4");
        for (int i = 0; i < 4; i++) step(1'b1, 8'sd0, "R3");
        step(1'b1, -8'sd1, "R3");
        step(1'b0, -8'sd7, "R4");
        step(1'b1, 8'sd0, "R3");

        // R8 full-scale sequences
        step(1'b1, -8'sd128, "R8");
        step(1'b1, 8'sd127, "R8");
        step(1'b1, -8'sd128, "R8");
        step(1'b1, 8'sd127, "R8");
        for (int i = 0; i < 4; i++) step(1'b1, -8'sd128, "R8");
        for (int i = 0; i < 4; i++) step(1'b1, 8'sd127, "R8");

        // R7 amplitude falls, drains to zero, and rises again
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < 12; i++) step(1'b1, DATA_W'($urandom), "R7");
            for (int i = 0; i < 20; i++) step(1'b1, low_amp(), "R7");
            for (int i = 0; i < 6; i++) step(1'b1, 8'sd0, "R7");
            for (int i = 0; i < 3; i++) step(1'b1, 8'sd3, "R7");
        end

        // R3 random mix of valid gaps, full-range and small samples
        for (int i = 0; i < 300; i++) begin
            logic v = ($urandom_range(3) != 0);
            logic [DATA_W-1:0] d = ($urandom_range(1) == 0) ? DATA_W'($urandom) : low_amp();
            step(v, d, "R3");
        end

        // R1 reset mid-stream discards history
        for (int i = 0; i < 3; i++) step(1'b1, -8'sd100, "R3");
        do_reset();
        step(1'b1, 8'sd5, "R1");
        step(1'b1, 8'sd0, "R1");
        step(1'b1, 8'sd0, "R1");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule